// File: doc/BRIEF.md
# Dual-Transition Fine Time Encoder

The block turns one snapshot of a tapped delay-line register array into a fine time value. Each clock a 64-bit word arrives. It holds a pulse train launched by a single hit: two falling transitions with a rising transition between them. The block finds the first two falling transitions and turns each into a 6-bit bin index. It outputs the sum of the two indices as a 7-bit fine time. Rising transitions are never encoded. Summing two positions halves the effect of any single unusually wide bin.

A falling transition sits at position k when bit k of the word is 0 and bit k+1 is 1. Positions therefore run from 0 to 62, and bit 63 can only act as the upper neighbour. The result is registered once, so it shows up one clock after the word is sampled. A valid flag comes with it. When the word holds fewer than two falling transitions, the flag is low and the fine time is forced to zero. An asynchronous active-low reset is released synchronously inside the block.

Top module: `dual_fall_encoder`

## Requirements
- R1: While reset is active, and after release until the first sampled word is encoded, valid_o is 0 and fine_o is 0.
- R2: A falling transition at position k (0..62) is bit k = 0 together with bit k+1 = 1. With exactly two such positions a < b, fine_o = a + b and valid_o = 1.
- R3: Rising transitions (bit k = 1 with bit k+1 = 0) do not change the result: a word with only rising transitions gives valid_o = 0, and a rising transition between two falling ones leaves their sum unchanged.
- R4: With zero or one falling transitions in the word, valid_o = 0 and fine_o = 0.
- R5: With more than two falling transitions, only the two lowest positions are summed.
- R6: The output for the word sampled at clock edge n appears just after edge n and holds until edge n+1. Words arriving on consecutive cycles are each encoded on their own.
- R7: Boundary positions work: a transition at position 0 and one at position 62 are both detected, a 0 in bit 63 on its own is not a transition, and a valid fine_o lies between 2 and 122.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the snapshot is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| snap_i | input | 64 | Delay-line register snapshot, bit 0 at the launch end |
| valid_o | output | 1 | High when two falling transitions were found |
| fine_o | output | 7 | Sum of the two lowest falling-transition positions, zero when not valid |

## Verification
The hardest cases to reach from the ports are the range limits and the multi-edge words. These are a transition at position 0 paired with one at position 62, a lone 0 in bit 63, and words with many falling transitions where only the lowest two may count. The stimulus builds each word from an all-ones background by clearing chosen bits or runs of bits. Clearing a run places one falling edge at its top and one rising edge below it, which recreates the launched three-edge shape at any offset. Words are also driven back to back to confirm the one-cycle latency.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  localparam int unsigned DFE_TAPS = 64;
  localparam int unsigned DFE_IDXW = $clog2(DFE_TAPS);
  localparam int unsigned DFE_SUMW = DFE_IDXW + 1;
endpackage

// File: rtl/dfe_rst_sync.sv
module dfe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dfe_fall_detect.sv
module dfe_fall_detect #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] word_i,
  output logic [W-2:0] fall_o
);
  for (genvar k = 0; k < W - 1; k++) begin : g_tap
    assign fall_o[k] = ~word_i[k] & word_i[k+1];
  end
endmodule

// File: rtl/dfe_lowest_idx.sv
module dfe_lowest_idx #(
  parameter int unsigned N  = 63,
  parameter int unsigned IW = 6
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign found_o = |req_i;
endmodule

// File: rtl/dual_fall_encoder.sv
module dual_fall_encoder #(
  parameter int unsigned TAPS = dfe_pkg::DFE_TAPS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TAPS-1:0] snap_i,
  output logic            valid_o,
  output logic [$clog2(TAPS):0] fine_o
);
  localparam int unsigned IDXW   = $clog2(TAPS);
  localparam int unsigned SUMW   = IDXW + 1;
  localparam int unsigned NPOS   = TAPS - 1;
  localparam int unsigned NEDGES = 2;

  logic            rst_q_n;
  logic [NPOS-1:0] fall;
  logic [NPOS-1:0] avail [NEDGES];
  logic            found [NEDGES];
  logic [IDXW-1:0] idx   [NEDGES];

  logic            valid_d, valid_q;
  logic [SUMW-1:0] fine_d,  fine_q;

  dfe_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q_n)
  );

  dfe_fall_detect #(.W(TAPS)) u_detect (
    .word_i (snap_i),
    .fall_o (fall)
  );

  assign avail[0] = fall;

  for (genvar e = 0; e < NEDGES; e++) begin : g_edge
    dfe_lowest_idx #(.N(NPOS), .IW(IDXW)) u_pick (
      .req_i   (avail[e]),
      .found_o (found[e]),
      .idx_o   (idx[e])
    );
    if (e + 1 < NEDGES) begin : g_mask
      assign avail[e+1] = avail[e] & (avail[e] - NPOS'(1));
    end
  end

  always_comb begin
    valid_d = found[0] & found[1];
    fine_d  = '0;
    if (valid_d) fine_d = SUMW'(idx[0]) + SUMW'(idx[1]);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q <= 1'b0;
      fine_q  <= '0;
    end else begin
      valid_q <= valid_d;
      fine_q  <= fine_d;
    end
  end

  assign valid_o = valid_q;
  assign fine_o  = fine_q;
endmodule

// File: rtl/dfe_checker.sv
module dfe_checker #(
  parameter int unsigned W    = 64,
  parameter int unsigned SUMW = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    snap_i,
  input logic            valid_o,
  input logic [SUMW-1:0] fine_o
);
  localparam int unsigned MAXSUM = 2 * W - 6;

  logic         seen_q;
  logic [W-1:0] snap_q;
  logic [W-2:0] falls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      snap_q <= '0;
    end else begin
      seen_q <= 1'b1;
      snap_q <= snap_i;
    end
  end

  assign falls_q = ~snap_q[W-2:0] & snap_q[W-1:1];

  // R4: invalid result is always zero
  a_r4_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> fine_o == '0);

  // R7: valid sum stays inside the reachable range
  a_r7_sum_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (fine_o >= SUMW'(2) && fine_o <= SUMW'(MAXSUM)));

  // R6: flag follows the falling-edge count of the previous word
  a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> valid_o == ($countones(falls_q) >= 2));

  // R6: an unchanged word keeps the output steady
  a_r6_stable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $stable(snap_i)) |=> ($stable(fine_o) && $stable(valid_o)));

  // R1: no valid output before a word has been encoded
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (!valid_o && fine_o == '0));
endmodule

bind dual_fall_encoder dfe_checker #(.W(TAPS), .SUMW(SUMW)) u_dfe_checker (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .snap_i  (snap_i),
  .valid_o (valid_o),
  .fine_o  (fine_o)
);

// File: tb/test_dual_fall_encoder.sv
`timescale 1ns/1ps
module test_dual_fall_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] snap = '1;
  logic        valid;
  logic [6:0]  fine;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dual_fall_encoder i_dual_fall_encoder (
    .clk     (clk),
    .rst_n   (rst_n),
    .snap_i  (snap),
    .valid_o (valid),
    .fine_o  (fine)
  );

  task automatic check(string req, logic ev, logic [6:0] ef);
    checks++;
    if (valid !== ev || fine !== ef) begin
      errors++;
      $display("FAIL %s: valid=%b fine=%0d expected valid=%b fine=%0d",
               req, valid, fine, ev, ef);
    end
  endtask

  // Drive a word on a falling edge, check the result one falling edge later.
  task automatic apply(string req, logic [63:0] w, logic ev, logic [6:0] ef);
    @(negedge clk);
    snap = w;
    @(negedge clk);
    check(req, ev, ef);
  endtask

  function automatic logic [63:0] clr(int a, int b);
    logic [63:0] w = '1;
    for (int i = a; i <= b; i++) w[i] = 1'b0;
    return w;
  endfunction

  task automatic t_reset();
    snap = ~((64'd1 << 5) | (64'd1 << 20));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 7'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 1'b0, 7'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_pairs();
    apply("R2 edges 5,20", ~((64'd1 << 5) | (64'd1 << 20)), 1'b1, 7'd25);
    apply("R2 edges 31,44", ~((64'd1 << 31) | (64'd1 << 44)), 1'b1, 7'd75);
  endtask

  task automatic t_rising();
    apply("R3 rising only", 64'h0000_0000_FFFF_FFFF, 1'b0, 7'd0);
    // three-edge launch shape: falls at 0 and 13, rise at 7
    apply("R3 launch shape", clr(0, 0) & clr(8, 13), 1'b1, 7'd13);
    apply("R3 launch shifted", clr(10, 10) & clr(18, 23), 1'b1, 7'd33);
  endtask

  task automatic t_few();
    apply("R4 all ones", '1, 1'b0, 7'd0);
    apply("R4 all zeros", '0, 1'b0, 7'd0);
    apply("R4 single edge", ~(64'd1 << 30), 1'b0, 7'd0);
  endtask

  task automatic t_many();
    apply("R5 edges 3,10,40", ~((64'd1 << 3) | (64'd1 << 10) | (64'd1 << 40)),
          1'b1, 7'd13);
    apply("R5 alternating", 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, 7'd2);
  endtask

  task automatic t_latency();
    @(negedge clk);
    snap = '1;
    @(negedge clk);
    check("R6 prior idle", 1'b0, 7'd0);
    snap = ~((64'd1 << 2) | (64'd1 << 9));
    #1;
    check("R6 before edge", 1'b0, 7'd0);
    @(negedge clk);
    check("R6 first word", 1'b1, 7'd11);
    snap = ~((64'd1 << 40) | (64'd1 << 50));
    @(negedge clk);
    check("R6 second word", 1'b1, 7'd90);
    snap = ~(64'd1 << 12);
    @(negedge clk);
    check("R6 third word", 1'b0, 7'd0);
  endtask

  task automatic t_bounds();
    apply("R7 edges 0,62", ~((64'd1 << 0) | (64'd1 << 62)), 1'b1, 7'd62);
    apply("R7 edges 60,62", ~((64'd1 << 60) | (64'd1 << 62)), 1'b1, 7'd122);
    apply("R7 bit63 zero", ~(64'd1 << 63), 1'b0, 7'd0);
    apply("R7 bit63 plus one", ~((64'd1 << 63) | (64'd1 << 4)), 1'b0, 7'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_pairs();
    t_rising();
    t_few();
    t_many();
    t_latency();
    t_bounds();
    finish_run();
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end
endmodule